// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the controller side of a boundary-scan test port. It follows TMS on each rising edge of the test clock through the sixteen-state controller graph. It holds a four-bit instruction and decides which data register sits between TDI and TDO during a data scan. Three data registers can be chosen: a one-bit bypass stage, a 32-bit identification word set by a parameter, and an external chain of boundary cells.

The boundary cells are not part of this block. The block reaches them through a serial return input and a set of strobes: select, capture, shift and update. It also raises a drive-mode output while the external-test instruction is active, so that the cells drive the pins from their update latches.

TDI and TMS are sampled on the rising edge of the test clock. TDO and its enable change on the falling edge. An active-low asynchronous reset returns the controller to Test-Logic-Reset at any time.

Top module: `tap_ctrl`

## Requirements
- R1: While trst_n is low, the controller is held in Test-Logic-Reset, tdo_en is 0 (this takes effect asynchronously), and the active instruction is IDCODE, so that ext_mode is 0.
- R2: After five consecutive rising edges of tck with tms high, from any state, the controller is in Test-Logic-Reset and the active instruction is IDCODE.
- R3: In Capture-IR the instruction shift stage loads 4'b0001. Its bits leave on TDO least significant first, so the first two bits out are 1 and then 0.
- R4: The instruction decodes as follows: 4'b1111 selects bypass, 4'b1110 selects the identification register, and 4'b0000 (external test) and 4'b0011 (sample/preload) both select the boundary chain. Every other code selects bypass.
- R5: The active instruction changes only on a falling edge of tck in Update-IR or in Test-Logic-Reset. Bits shifted in during Shift-IR leave it unchanged.
- R6: tdo_en rises or falls only on a falling edge of tck. It is 1 exactly while the controller is in Shift-IR or Shift-DR. TDO carries the least significant bit of the selected register, updated on that same falling edge.
- R7: With the identification register selected, Capture-DR loads the 32-bit parameter ID_WORD, whose bit 0 is 1. The word shifts out least significant bit first, and TDI enters at bit 31.
- R8: With bypass selected, Capture-DR loads 0 into the bypass stage. While shifting, TDO repeats TDI with a delay of one clock.
- R9: With the boundary chain selected, bsr_sel is 1. bsr_capture is 1 in Capture-DR, bsr_shift is 1 in Shift-DR and bsr_update is 1 in Update-DR. In Shift-DR, TDO repeats bsr_tdo. With any other instruction, all four outputs are 0.
- R10: ext_mode is 1 exactly while the active instruction is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_en | output | 1 | Output enable for tdo; low means high impedance |
| bsr_tdo | input | 1 | Serial return from the boundary chain |
| bsr_sel | output | 1 | Boundary chain is the selected data register |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| ext_mode | output | 1 | Boundary cells drive pins from update latches |

## Verification
A wrong controller state shows within one clock. The strobes to the boundary chain are decoded from the state, and tdo_en follows the state half a clock later, so a wrong transition changes one of them on the next edge. A wrong active instruction shows on ext_mode and bsr_sel at the falling edge where it is loaded. A bad shift stage, capture value or decode shows on TDO in the first bits of the next scan. A reference model is compared with every output on both clock edges, so such a fault is reported in the cycle where it first appears.

// File: rtl/tap_ctrl.sv
module tap_ctrl #(
  parameter logic [31:0] ID_WORD = 32'h4B5C_60E3
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_en,
  input  logic bsr_tdo,
  output logic bsr_sel,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update,
  output logic ext_mode
);

  localparam int IRW = 4;
  localparam int IDW = $bits(ID_WORD);
  localparam logic [IRW-1:0] OP_EXT    = 4'b0000;
  localparam logic [IRW-1:0] OP_SAMP   = 4'b0011;
  localparam logic [IRW-1:0] OP_ID     = 4'b1110;
  localparam logic [IRW-1:0] IR_CAPVAL = 4'b0001;

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_st_t;

  tap_st_t state, nxt;
  logic [IRW-1:0] ir_sr, ir;
  logic [IDW-1:0] id_sr;
  logic           byp;
  logic           sel_id, dr_bit;

  always_comb begin
    case (state)
      S_TLR:    nxt = tms ? S_TLR    : S_RTI;
      S_RTI:    nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nxt = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  nxt = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: nxt = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: nxt = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: nxt = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: nxt = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: nxt = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  nxt = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: nxt = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: nxt = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: nxt = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: nxt = tms ? S_SEL_DR : S_RTI;
      default:  nxt = S_TLR;
    endcase
  end

  assign bsr_sel     = (ir == OP_EXT) || (ir == OP_SAMP);
  assign sel_id      = (ir == OP_ID);
  assign ext_mode    = (ir == OP_EXT);
  assign bsr_capture = bsr_sel && (state == S_CAP_DR);
  assign bsr_shift   = bsr_sel && (state == S_SH_DR);
  assign bsr_update  = bsr_sel && (state == S_UPD_DR);
  assign dr_bit      = bsr_sel ? bsr_tdo : (sel_id ? id_sr[0] : byp);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state <= S_TLR;
      ir_sr <= IR_CAPVAL;
      id_sr <= ID_WORD;
      byp   <= 1'b0;
    end else begin
      state <= nxt;
      case (state)
        S_CAP_IR: ir_sr <= IR_CAPVAL;
        S_SH_IR:  ir_sr <= {tdi, ir_sr[IRW-1:1]};
        S_CAP_DR: begin
          byp <= 1'b0;
          if (sel_id) id_sr <= ID_WORD;
        end
        S_SH_DR: begin
          byp <= tdi;
          if (sel_id) id_sr <= {tdi, id_sr[IDW-1:1]};
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir     <= OP_ID;
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      if (state == S_TLR)         ir <= OP_ID;
      else if (state == S_UPD_IR) ir <= ir_sr;
      tdo_en <= (state == S_SH_IR) || (state == S_SH_DR);
      if (state == S_SH_IR)      tdo <= ir_sr[0];
      else if (state == S_SH_DR) tdo <= dr_bit;
    end
  end

  logic [2:0] tms_run;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)              tms_run <= 3'd0;
    else if (!tms)            tms_run <= 3'd0;
    else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
  end

  assert_reset_ir_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_TLR) |-> (ir == OP_ID));

  assert_five_tms_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (tms_run == 3'd5) |-> (state == S_TLR));

  assert_capture_ir_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_CAP_IR) |=> (ir_sr[1:0] == 2'b01));

  assert_ir_hold_R5: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_SH_IR) |=> $stable(ir));

  assert_ir_change_R5: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(ir) |-> ((state == S_UPD_IR) || (state == S_TLR)));

  assert_tdo_en_R6: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> ((state == S_SH_IR) || (state == S_SH_DR)));

endmodule

// File: tb/tap_ctrl_bench.sv
module tap_ctrl_bench;
  localparam logic [31:0] IDV = 32'h4B5C_60E3;

  logic tck = 1'b0;
  logic trst_n, tms, tdi;
  logic tdo, tdo_en, bsr_sel, bsr_capture, bsr_shift, bsr_update, ext_mode;
  logic [7:0] chain = 8'h00;
  wire bsr_tdo = chain[0];

  tap_ctrl #(.ID_WORD(IDV)) u_tap_ctrl (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_en(tdo_en), .bsr_tdo(bsr_tdo), .bsr_sel(bsr_sel),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
    .bsr_update(bsr_update), .ext_mode(ext_mode)
  );

  always #2 tck = ~tck;

  localparam int TLR = 0, RTI = 1, SDS = 2, CDR = 3, SDR = 4, E1D = 5,
                 PDR = 6, E2D = 7, UDR = 8, SIS = 9, CIR = 10, SIR = 11,
                 E1I = 12, PIR = 13, E2I = 14, UIR = 15;

  int ms;
  logic [3:0]  msr, mir;
  logic [31:0] mid;
  logic        mbyp, mtdo, men;
  int total = 0, bad = 0;
  string cur_req = "R1";

  function automatic int nextst(int s, logic t);
    case (s)
      TLR: return t ? TLR : RTI;
      RTI: return t ? SDS : RTI;
      SDS: return t ? SIS : CDR;
      CDR, SDR: return t ? E1D : SDR;
      E1D: return t ? UDR : PDR;
      PDR: return t ? E2D : PDR;
      E2D: return t ? UDR : SDR;
      SIS: return t ? TLR : CIR;
      CIR, SIR: return t ? E1I : SIR;
      E1I: return t ? UIR : PIR;
      PIR: return t ? E2I : PIR;
      E2I: return t ? UIR : SIR;
      default: return t ? SDS : RTI;
    endcase
  endfunction

  function automatic logic is_bsr(logic [3:0] c);
    return (c == 4'b0000) || (c == 4'b0011);
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    ms = TLR; mir = 4'b1110; men = 1'b0; mtdo = 1'b0;
  endtask

  task automatic step(logic t, logic d);
    tms = t; tdi = d;
    @(posedge tck); #1;
    case (ms)
      CIR: msr = 4'b0001;
      SIR: msr = {d, msr[3:1]};
      CDR: begin
        mbyp = 1'b0;
        if (mir == 4'b1110) mid = IDV;
        if (is_bsr(mir)) chain = 8'hA5;
      end
      SDR: begin
        if (is_bsr(mir)) chain = {d, chain[7:1]};
        else if (mir == 4'b1110) mid = {d, mid[31:1]};
        else mbyp = d;
      end
      default: ;
    endcase
    ms = nextst(ms, t);
    check("R9", "bsr_sel", bsr_sel, is_bsr(mir));
    check("R9", "bsr_capture", bsr_capture, is_bsr(mir) && ms == CDR);
    check("R9", "bsr_shift", bsr_shift, is_bsr(mir) && ms == SDR);
    check("R9", "bsr_update", bsr_update, is_bsr(mir) && ms == UDR);
    check(cur_req, "ext_mode@rise", ext_mode, mir == 4'b0000);
    @(negedge tck); #1;
    if (ms == TLR) mir = 4'b1110;
    else if (ms == UIR) mir = msr;
    men = (ms == SIR) || (ms == SDR);
    if (ms == SIR) mtdo = msr[0];
    else if (ms == SDR)
      mtdo = is_bsr(mir) ? chain[0] : ((mir == 4'b1110) ? mid[0] : mbyp);
    check("R6", "tdo_en", tdo_en, men);
    if (men) check(cur_req, "tdo", tdo, mtdo);
    check(cur_req, "ext_mode@fall", ext_mode, mir == 4'b0000);
  endtask

  task automatic to_rti();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic load_ir(logic [3:0] code);
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(i == 3, code[i]);
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  task automatic scan_dr(int n, logic [63:0] pat, bit pause);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      if (pause && i == 2 && n > 3) begin
        step(1'b1, pat[i]); step(1'b0, 1'b0); step(1'b0, 1'b0);
        step(1'b1, 1'b0); step(1'b0, 1'b0);
      end else step(i == n - 1, pat[i]);
    end
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  initial begin
    repeat (50000) @(posedge tck);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    msr = 4'b0001; mid = IDV; mbyp = 1'b0;
    model_reset();
    repeat (3) @(negedge tck);
    #1;
    cur_req = "R1";
    check("R1", "tdo_en in reset", tdo_en, 1'b0);
    check("R1", "ext_mode in reset", ext_mode, 1'b0);
    check("R1", "bsr_sel in reset", bsr_sel, 1'b0);
    trst_n = 1'b1;
    step(1'b0, 1'b0);
    cur_req = "R7";
    scan_dr(40, 64'h0123_4567_89AB_CDEF, 1'b0);
    cur_req = "R3";
    load_ir(4'b1111);
    cur_req = "R8";
    scan_dr(12, 64'h0000_0000_0000_0B2D, 1'b0);
    cur_req = "R4";
    load_ir(4'b0101);
    scan_dr(9, 64'h0000_0000_0000_0153, 1'b0);
    load_ir(4'b1000);
    scan_dr(6, 64'h0000_0000_0000_002A, 1'b0);
    cur_req = "R10";
    load_ir(4'b0000);
    scan_dr(12, 64'h0000_0000_0000_0C3A, 1'b0);
    cur_req = "R9";
    load_ir(4'b0011);
    scan_dr(10, 64'h0000_0000_0000_02F1, 1'b1);
    cur_req = "R5";
    load_ir(4'b0000);
    load_ir(4'b1110);
    cur_req = "R6";
    scan_dr(34, 64'h0000_0002_DEAD_BEEF, 1'b1);
    cur_req = "R2";
    load_ir(4'b0000);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b1); step(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
    check("R2", "ext_mode after five tms", ext_mode, 1'b0);
    step(1'b0, 1'b0);
    scan_dr(33, 64'h0000_0001_5555_AAAA, 1'b0);
    cur_req = "R1";
    load_ir(4'b0000);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b1); step(1'b0, 1'b0);
    trst_n = 1'b0;
    #1;
    check("R1", "tdo_en async reset", tdo_en, 1'b0);
    check("R1", "ext_mode async reset", ext_mode, 1'b0);
    model_reset();
    @(posedge tck);
    @(negedge tck); #1;
    trst_n = 1'b1;
    step(1'b0, 1'b0);
    scan_dr(32, 64'h0000_0000_0F0F_3C3C, 1'b0);
    to_rti();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule